// File: doc/BRIEF.md
# Window Watchdog with Reset Pulse

This block supervises an external controller that must prove it is alive by sending a service strobe at the right time. After it starts, the watchdog runs a closed window and then an open window. A strobe that arrives while the window is closed is treated as a fault. If the open window expires with no strobe, that is also a fault. A strobe inside the open window is accepted and starts a new cycle, which begins again with a closed window. Either fault pulls the active-low reset output down for a fixed number of cycles. Once the output is released, the watchdog starts over.

Both window lengths come from a 3-bit code. The lengths are counted in ticks of an internal prescaler. An enable bit can turn supervision off completely. A qualified supply reset comes in from outside. While the supply is low, it holds the reset output low and keeps the watchdog off. The reset output is the AND of the supply reset and the watchdog's own reset, and both are active-low. Two cause flags record whether the last watchdog fault was early or missed, and a read strobe clears them.

The block has no data stream, so it has no valid/ready interface. All of its pins are plain level or single-cycle strobe controls, sampled on the rising clock edge.

Top module: `win_watchdog`

## Requirements
- R1: While `cfg_enable` is low, the watchdog never asserts a fault. If `cfg_enable` is cleared during a fault pulse, `rst_out_n` is released on the next clock edge, unless the supply reset holds it low.
- R2: The watchdog starts one clock edge after it is allowed to run: `cfg_enable` high, `supply_rst_n` high and `rst_out_n` high. After a fault pulse ends, `rst_out_n` is high for exactly one edge before the new closed window starts.
- R3: A `kick` sampled during any cycle of the closed window, including its last cycle, starts a fault on that edge.
- R4: If no `kick` arrives by the last cycle of the open window, a fault starts on that edge.
- R5: A `kick` sampled during any cycle of the open window, including its last cycle, is accepted. A new closed window starts on the next cycle.
- R6: A fault holds `rst_out_n` low for exactly RST_TICKS×PRESC clock cycles.
- R7: While `supply_rst_n` is low, `rst_out_n` is low, the watchdog is held off, and `kick` is ignored. After `supply_rst_n` returns high, the watchdog starts per R2 and sets no early flag from strobes sent while the supply was low.
- R8: With code c on `cfg_sel`, the closed window lasts CL_BASE×(c+1)×PRESC cycles and the open window lasts OP_BASE×(c+1)×PRESC cycles. The code is captured only when a closed window starts.
- R9: A fault sets `cause_early` if it was caused by an early kick (R3). It sets `cause_missed` if it was caused by a missed kick (R4). A fault also clears the other flag, so at most one flag is high at a time. `stat_rd` clears both flags on the next edge, and a fault on that same edge takes priority over the clear.
- R10: During `rst_n` low, both cause flags are 0, the watchdog is idle, and `rst_out_n` equals `supply_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Logic reset, active low |
| supply_rst_n | input | 1 | Qualified supply reset; low means undervoltage |
| cfg_enable | input | 1 | Watchdog enable |
| cfg_sel | input | 3 | Window timing code |
| kick | input | 1 | Service strobe, one cycle |
| stat_rd | input | 1 | Cause flag read/clear strobe |
| rst_out_n | output | 1 | Reset output, active low |
| cause_early | output | 1 | Last fault was an early kick |
| cause_missed | output | 1 | Last fault was a missed kick |

## Verification
On every cycle, the assertions check the following:
- an early kick faults on the next edge;
- an open-window kick returns the watchdog to the closed window;
- an undervoltage holds the watchdog off;
- the pulse length counted in clock cycles;
- the rule that no window runs in the cycle the pulse is released;
- that the cause flags are never both high.

The actual lengths of both windows for each of the eight codes can only be shown by the bench's sweep, which kicks at the window boundaries and measures when the fault arrives. The bench scenarios also cover:
- the one-cycle restart gap after a pulse;
- capture of the code at the start of a window;
- set taking priority over clear on the flags.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

  typedef enum logic [1:0] {
    WD_IDLE   = 2'd0,
    WD_CLOSED = 2'd1,
    WD_OPEN   = 2'd2,
    WD_PULSE  = 2'd3
  } wwd_state_e;

  // Window length in prescaled ticks for a given code: base scaled by (code+1).
  function automatic int unsigned wwd_len(input int unsigned base, input logic [2:0] code);
    return base * (int'(code) + 1);
  endfunction

  function automatic int unsigned wwd_max3(input int unsigned a, input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wwd_prescaler.sv
module wwd_prescaler #(
  parameter int unsigned PRESC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);

  generate
    if (PRESC <= 1) begin : g_bypass
      logic unused_clr;
      logic unused_clk;
      assign unused_clr = clr ^ rst_n;
      assign unused_clk = clk;
      assign tick       = 1'b1;
    end else begin : g_count
      localparam int unsigned PW = $clog2(PRESC);
      localparam logic [PW-1:0] LAST = PW'(PRESC - 1);
      logic [PW-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (clr || cnt_q == LAST) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end

      assign tick = (cnt_q == LAST);
    end
  endgenerate

endmodule

// File: rtl/wwd_window_ctrl.sv
module wwd_window_ctrl
  import wwd_pkg::*;
#(
  parameter int unsigned CL_BASE   = 4,
  parameter int unsigned OP_BASE   = 8,
  parameter int unsigned RST_TICKS = 8,
  parameter int unsigned LW        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             kick,
  input  logic             tick,
  input  logic [2:0]       sel,
  output logic             restart,
  output logic             set_early,
  output logic             set_missed,
  output wwd_state_e       state
);

  localparam logic [LW-1:0] PULSE_LAST = LW'(RST_TICKS - 1);

  wwd_state_e    state_q, state_d;
  logic [LW-1:0] tcnt_q;
  logic [LW-1:0] cl_len_q, op_len_q;
  logic          latch;
  logic          cl_end, op_end, pulse_end;

  assign cl_end    = tick && (tcnt_q == cl_len_q - LW'(1));
  assign op_end    = tick && (tcnt_q == op_len_q - LW'(1));
  assign pulse_end = tick && (tcnt_q == PULSE_LAST);

  always_comb begin
    state_d    = state_q;
    restart    = 1'b0;
    latch      = 1'b0;
    set_early  = 1'b0;
    set_missed = 1'b0;
    if (!run) begin
      state_d = WD_IDLE;
      restart = 1'b1;
    end else begin
      unique case (state_q)
        WD_IDLE: begin
          state_d = WD_CLOSED;
          restart = 1'b1;
          latch   = 1'b1;
        end
        WD_CLOSED: begin
          if (kick) begin
            state_d   = WD_PULSE;
            restart   = 1'b1;
            set_early = 1'b1;
          end else if (cl_end) begin
            state_d = WD_OPEN;
            restart = 1'b1;
          end
        end
        WD_OPEN: begin
          if (kick) begin
            state_d = WD_CLOSED;
            restart = 1'b1;
            latch   = 1'b1;
          end else if (op_end) begin
            state_d    = WD_PULSE;
            restart    = 1'b1;
            set_missed = 1'b1;
          end
        end
        WD_PULSE: begin
          if (pulse_end) begin
            state_d = WD_IDLE;
            restart = 1'b1;
          end
        end
        default: begin
          state_d = WD_IDLE;
          restart = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WD_IDLE;
      tcnt_q   <= '0;
      cl_len_q <= LW'(CL_BASE);
      op_len_q <= LW'(OP_BASE);
    end else begin
      state_q <= state_d;
      if (restart) begin
        tcnt_q <= '0;
      end else if (tick) begin
        tcnt_q <= tcnt_q + 1'b1;
      end
      if (latch) begin
        cl_len_q <= LW'(wwd_len(CL_BASE, sel));
        op_len_q <= LW'(wwd_len(OP_BASE, sel));
      end
    end
  end

  assign state = state_q;

endmodule

// File: rtl/wwd_cause_reg.sv
module wwd_cause_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_early,
  input  logic set_missed,
  input  logic rd_clr,
  output logic early,
  output logic missed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      early  <= 1'b0;
      missed <= 1'b0;
    end else if (set_early) begin
      early  <= 1'b1;
      missed <= 1'b0;
    end else if (set_missed) begin
      early  <= 1'b0;
      missed <= 1'b1;
    end else if (rd_clr) begin
      early  <= 1'b0;
      missed <= 1'b0;
    end
  end

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog
  import wwd_pkg::*;
#(
  parameter int unsigned PRESC     = 16,
  parameter int unsigned CL_BASE   = 4,
  parameter int unsigned OP_BASE   = 8,
  parameter int unsigned RST_TICKS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_rst_n,
  input  logic       cfg_enable,
  input  logic [2:0] cfg_sel,
  input  logic       kick,
  input  logic       stat_rd,
  output logic       rst_out_n,
  output logic       cause_early,
  output logic       cause_missed
);

  localparam int unsigned MAX_BASE = wwd_max3(CL_BASE, OP_BASE, RST_TICKS);
  localparam int unsigned LW       = $clog2(MAX_BASE * 8 + 1);

  logic       run;
  logic       tick;
  logic       restart;
  logic       set_early, set_missed;
  wwd_state_e state;
  logic       in_closed, in_open, wd_fault;

  assign run = cfg_enable & supply_rst_n;

  wwd_prescaler #(.PRESC(PRESC)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (restart),
    .tick (tick)
  );

  wwd_window_ctrl #(
    .CL_BASE  (CL_BASE),
    .OP_BASE  (OP_BASE),
    .RST_TICKS(RST_TICKS),
    .LW       (LW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .kick      (kick),
    .tick      (tick),
    .sel       (cfg_sel),
    .restart   (restart),
    .set_early (set_early),
    .set_missed(set_missed),
    .state     (state)
  );

  wwd_cause_reg u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_early (set_early),
    .set_missed(set_missed),
    .rd_clr    (stat_rd),
    .early     (cause_early),
    .missed    (cause_missed)
  );

  assign in_closed = (state == WD_CLOSED);
  assign in_open   = (state == WD_OPEN);
  assign wd_fault  = (state == WD_PULSE);
  assign rst_out_n = supply_rst_n & ~wd_fault;

endmodule

// File: rtl/wwd_checker.sv
module wwd_checker #(
  parameter int unsigned PULSE_CYC = 128
) (
  input logic clk,
  input logic rst_n,
  input logic supply_rst_n,
  input logic cfg_enable,
  input logic kick,
  input logic rst_out_n,
  input logic cause_early,
  input logic cause_missed,
  input logic in_closed,
  input logic in_open,
  input logic wd_fault
);

  int unsigned pcnt;
  logic        run;
  assign run = cfg_enable && supply_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pcnt <= 0;
    else if (wd_fault) pcnt <= pcnt + 1;
    else               pcnt <= 0;
  end

  // R1: disabled for a full cycle means no fault
  p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !$past(cfg_enable)) |-> !wd_fault);

  // R2: release of the pulse leaves one idle cycle before the next window
  p_idle_after_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_fault) |-> (!in_closed && !in_open));

  // R3: kick in closed window faults with early cause
  p_early_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_closed && kick && run) |=> (wd_fault && cause_early));

  // R5: kick in open window restarts the closed window
  p_open_kick_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_open && kick && run) |=> (in_closed && !wd_fault));

  // R6: pulse holds for its full length, then ends
  p_pulse_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_fault && run && pcnt < PULSE_CYC - 1) |=> wd_fault);

  p_pulse_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_fault && run && pcnt == PULSE_CYC - 1) |=> !wd_fault);

  // R7: undervoltage drives output low and holds watchdog off
  p_supply_low_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_rst_n |-> !rst_out_n);

  p_supply_holdoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_rst_n |=> (!in_closed && !in_open && !wd_fault));

  // R9: at most one cause flag
  p_cause_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cause_early, cause_missed}));

endmodule

bind win_watchdog wwd_checker #(.PULSE_CYC(RST_TICKS * PRESC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .supply_rst_n(supply_rst_n),
  .cfg_enable  (cfg_enable),
  .kick        (kick),
  .rst_out_n   (rst_out_n),
  .cause_early (cause_early),
  .cause_missed(cause_missed),
  .in_closed   (in_closed),
  .in_open     (in_open),
  .wd_fault    (wd_fault)
);

// File: tb/win_watchdog_bench.sv
`timescale 1ns/1ps
module win_watchdog_bench;

  localparam int PRESC = 2, CLB = 2, OPB = 3, RTK = 3;
  localparam int PULSE = RTK * PRESC;

  logic clk = 1'b0;
  logic rst_n, supply_rst_n, cfg_enable, kick, stat_rd;
  logic [2:0] cfg_sel;
  logic rst_out_n, cause_early, cause_missed;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  win_watchdog #(.PRESC(PRESC), .CL_BASE(CLB), .OP_BASE(OPB), .RST_TICKS(RTK)) u_win_watchdog (
    .clk(clk), .rst_n(rst_n), .supply_rst_n(supply_rst_n), .cfg_enable(cfg_enable),
    .cfg_sel(cfg_sel), .kick(kick), .stat_rd(stat_rd), .rst_out_n(rst_out_n),
    .cause_early(cause_early), .cause_missed(cause_missed));

  function automatic int ncl(input int s); return CLB * (s + 1) * PRESC; endfunction
  function automatic int nop(input int s); return OPB * (s + 1) * PRESC; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Disable, set code, enable: returns at the negedge after the watchdog started.
  task automatic start_wd(input int s);
    kick = 0;
    cfg_enable = 0;
    repeat (2) @(negedge clk);
    cfg_sel = 3'(s);
    cfg_enable = 1;
    @(negedge clk);
  endtask

  // Kick before edge number k (0 = never); return the edge index where output goes low.
  task automatic run_to_fault(input int k, input int limit, output int t);
    t = -1;
    for (int i = 1; i <= limit; i++) begin
      kick = (i == k);
      @(negedge clk);
      kick = 0;
      if (!rst_out_n) begin
        t = i;
        return;
      end
    end
  endtask

  task automatic measure_pulse(output int len);
    len = 0;
    while (!rst_out_n && len < 1000) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog timeout actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int t, len, exp_t, ks[5];
    rst_n = 0; supply_rst_n = 1; cfg_enable = 0; kick = 0; stat_rd = 0; cfg_sel = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(rst_out_n === 1'b1, "R10 out high in reset", int'(rst_out_n), 1);
    check(cause_early === 1'b0 && cause_missed === 1'b0, "R10 flags clear",
          int'({cause_early, cause_missed}), 0);
    supply_rst_n = 0;
    @(negedge clk);
    check(rst_out_n === 1'b0, "R10 out follows supply", int'(rst_out_n), 0);
    supply_rst_n = 1;
    rst_n = 1;
    @(negedge clk);

    // R3 R4 R5 R6 R8 R9 R2: sweep every code at the window boundaries
    for (int s = 0; s < 8; s++) begin
      ks[0] = 0; ks[1] = 1; ks[2] = ncl(s); ks[3] = ncl(s) + 1; ks[4] = ncl(s) + nop(s);
      for (int j = 0; j < 5; j++) begin
        start_wd(s);
        run_to_fault(ks[j], 400, t);
        if (ks[j] == 0)              exp_t = ncl(s) + nop(s);
        else if (ks[j] <= ncl(s))    exp_t = ks[j];
        else                         exp_t = ks[j] + ncl(s) + nop(s);
        check(t == exp_t, (ks[j] == 0) ? "R4 R8 missed timing" :
              (ks[j] <= ncl(s)) ? "R3 R8 early timing" : "R5 R8 open kick restart", t, exp_t);
        if (ks[j] >= 1 && ks[j] <= ncl(s))
          check(cause_early && !cause_missed, "R9 early cause", int'({cause_early, cause_missed}), 2);
        else
          check(!cause_early && cause_missed, "R9 missed cause", int'({cause_early, cause_missed}), 1);
        measure_pulse(len);
        check(len == PULSE, "R6 pulse length", len, PULSE);
        run_to_fault(0, 400, t);
        check(t == ncl(s) + nop(s) + 1, "R2 restart after release", t, ncl(s) + nop(s) + 1);
      end
    end

    // R9: read strobe clears flags
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
    check(!cause_early && !cause_missed, "R9 read clears", int'({cause_early, cause_missed}), 0);

    // R9: set beats clear on the same edge
    start_wd(0);
    stat_rd = 1;
    run_to_fault(0, 400, t);
    check(cause_missed === 1'b1, "R9 set beats clear", int'(cause_missed), 1);
    stat_rd = 0;
    @(negedge clk);

    // R8: code captured only at window start
    start_wd(0);
    cfg_sel = 3'd7;
    run_to_fault(0, 400, t);
    check(t == ncl(0) + nop(0), "R8 code held mid-window", t, ncl(0) + nop(0));
    measure_pulse(len);
    run_to_fault(0, 400, t);
    check(t == ncl(7) + nop(7) + 1, "R8 new code at next window", t, ncl(7) + nop(7) + 1);

    // R1: disabled means no reset
    start_wd(0);
    cfg_enable = 0;
    begin
      int lows = 0;
      for (int i = 0; i < 200; i++) begin
        kick = (i % 3 == 0);
        @(negedge clk);
        if (!rst_out_n) lows++;
      end
      kick = 0;
      check(lows == 0, "R1 disabled never resets", lows, 0);
    end

    // R1: disabling aborts a running pulse
    start_wd(0);
    run_to_fault(1, 10, t);
    check(!rst_out_n, "R1 pulse started", int'(rst_out_n), 0);
    cfg_enable = 0;
    @(negedge clk);
    check(rst_out_n === 1'b1, "R1 disable aborts pulse", int'(rst_out_n), 1);

    // R7: supply low holds output low, kicks ignored
    start_wd(1);
    stat_rd = 1;
    @(negedge clk);
    stat_rd = 0;
    supply_rst_n = 0;
    begin
      int highs = 0;
      for (int i = 0; i < 50; i++) begin
        kick = i[0];
        @(negedge clk);
        if (rst_out_n) highs++;
      end
      kick = 0;
      check(highs == 0, "R7 output low under supply reset", highs, 0);
    end
    check(!cause_early && !cause_missed, "R7 kicks ignored", int'({cause_early, cause_missed}), 0);
    supply_rst_n = 1;
    @(negedge clk);
    check(rst_out_n === 1'b1, "R7 output released", int'(rst_out_n), 1);
    run_to_fault(0, 400, t);
    check(t == ncl(1) + nop(1), "R7 restart after supply", t, ncl(1) + nop(1));
    check(cause_missed && !cause_early, "R7 no early flag", int'({cause_early, cause_missed}), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule